// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings a DDR3 device from power-on to an operational state. It owns the memory reset, the clock enable and the command/address pins while the device starts up. It walks through a fixed script: a long reset pulse, a wait before the clock is enabled, three mode-register writes, a long ZQ calibration, a precharge of every bank and one refresh. Each command is separated from the one before it by a programmable minimum number of controller clocks.

After the refresh, the sequencer drives NOP for a settling window and then raises a completion flag. The normal command engine then takes over the pins. If the controller reset is asserted at any point, everything starts again from the first step with all counts cleared.

Every gap is a parameter that gives the number of clocks the real gap must exceed. The sequencer always uses the shortest legal gap, which is that parameter plus one clock.

Top module: `ddr3_powerup_seq`

## Requirements
- R1: While `rst_n` is low, `mem_reset_n`, `mem_cke` and `init_done` are 0 and `mem_cs_n` is 1. After `rst_n` is released, `mem_reset_n` stays low for T_RESET+1 clocks and then rises.
- R2: `mem_cke` rises T_CKE+1 clocks after `mem_reset_n` rises. It is never high while `mem_reset_n` is low, and it stays high until reset.
- R3: Commands are coded on {ras_n,cas_n,we_n} with `mem_cs_n` low: mode write 000, refresh 001, precharge 010, ZQ calibration 110, NOP 111. Before `mem_cke` rises the pins show deselect (`mem_cs_n`=1). Between scripted commands they show NOP.
- R4: The first mode write goes to bank 2 with address MR2_VAL (default 0x040), T_XPR+1 clocks after `mem_cke` rises. No mode write names a bank above 2.
- R5: The second mode write goes to bank 1 with address MR1_VAL, T_MRD+1 clocks after the first. The third goes to bank 0 with address MR0_VAL (default 0x210), T_MRD+1 clocks after the second.
- R6: The ZQ calibration carries address 0x400 (bit 10 set, long form). It comes T_MOD+1 clocks after the third mode write.
- R7: A precharge with address 0x400 (bit 10 set, all banks) comes T_ZQINIT+1 clocks after the ZQ calibration. A refresh with bank 0 and address 0 comes T_RP+1 clocks after the precharge.
- R8: After the refresh, only NOPs appear for T_SETTLE+1 clocks. `init_done` rises in the next clock, T_SETTLE+2 clocks after the refresh.
- R9: `init_done` rises once per reset and stays high. While it is high, the pins hold NOP with `mem_cke` high, and no further event occurs.
- R10: Asserting `rst_n` low at any step returns the block to the R1 state. The next release replays the whole script with full gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| mem_reset_n | output | 1 | Device reset, active low |
| mem_cke | output | 1 | Device clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address pins |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
The hardest cases to reach are resets that land partway through the script: one during the clock-enable wait, and one just after the last mode write while the calibration wait is running. A correct restart is visible only through the timing of the replayed sequence. The bench runs with short gap parameters so that it can complete several full and partial runs. For each run, a driver task queues the expected events (pin rises, commands and their cycle numbers) up to the chosen cut point. Once the queue drains, the bench pulls reset and then checks that the next run repeats every gap in full. Any event outside the queue counts as a miscompare, so a stray command or a late edge after done is caught.

// File: rtl/ddr3_powerup_seq.sv
module ddr3_powerup_seq #(
  parameter int BA_W     = 3,
  parameter int ADDR_W   = 14,
  parameter int T_RESET  = 40000,
  parameter int T_CKE    = 100000,
  parameter int T_XPR    = 147,
  parameter int T_MRD    = 3,
  parameter int T_MOD    = 11,
  parameter int T_ZQINIT = 512,
  parameter int T_RP     = 3,
  parameter int T_SETTLE = 140,
  parameter logic [15:0] MR2_VAL = 16'h0040,
  parameter logic [15:0] MR1_VAL = 16'h0044,
  parameter logic [15:0] MR0_VAL = 16'h0210
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_reset_n,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_GAP = max2(max2(max2(T_RESET, T_CKE), max2(T_XPR, T_ZQINIT)),
                                max2(max2(T_MRD, T_MOD), max2(T_RP, T_SETTLE)));
  localparam int CNT_W   = $clog2(MAX_GAP + 1) + 1;
  localparam logic [ADDR_W-1:0] A10 = ADDR_W'(11'h400);

  typedef enum logic [3:0] {
    S_RST, S_CKEW,
    S_W_MR2, S_C_MR2, S_W_MR1, S_C_MR1, S_W_MR0, S_C_MR0,
    S_W_ZQ, S_C_ZQ, S_W_PRE, S_C_PRE, S_W_REF, S_C_REF,
    S_SETTLE, S_DONE
  } step_t;

  step_t            st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             is_cmd;
  logic             advance;
  logic [2:0]       cmd;

  always_comb begin
    case (st)
      S_RST:    lim = CNT_W'(T_RESET);
      S_CKEW:   lim = CNT_W'(T_CKE);
      S_W_MR2:  lim = CNT_W'(T_XPR);
      S_W_MR1,
      S_W_MR0:  lim = CNT_W'(T_MRD - 1);
      S_W_ZQ:   lim = CNT_W'(T_MOD - 1);
      S_W_PRE:  lim = CNT_W'(T_ZQINIT - 1);
      S_W_REF:  lim = CNT_W'(T_RP - 1);
      S_SETTLE: lim = CNT_W'(T_SETTLE);
      default:  lim = '0;
    endcase
  end

  assign is_cmd  = (st == S_C_MR2) || (st == S_C_MR1) || (st == S_C_MR0) ||
                   (st == S_C_ZQ)  || (st == S_C_PRE) || (st == S_C_REF);
  assign advance = (st != S_DONE) && (is_cmd || (cnt == lim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RST;
      cnt <= '0;
    end else if (advance) begin
      st  <= step_t'(st + 4'd1);
      cnt <= '0;
    end else if (st != S_DONE) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    cmd      = 3'b111;
    mem_ba   = '0;
    mem_addr = '0;
    case (st)
      S_C_MR2: begin cmd = 3'b000; mem_ba = BA_W'(2); mem_addr = MR2_VAL[ADDR_W-1:0]; end
      S_C_MR1: begin cmd = 3'b000; mem_ba = BA_W'(1); mem_addr = MR1_VAL[ADDR_W-1:0]; end
      S_C_MR0: begin cmd = 3'b000; mem_ba = BA_W'(0); mem_addr = MR0_VAL[ADDR_W-1:0]; end
      S_C_ZQ:  begin cmd = 3'b110; mem_addr = A10; end
      S_C_PRE: begin cmd = 3'b010; mem_addr = A10; end
      S_C_REF: begin cmd = 3'b001; end
      default: ;
    endcase
  end

  assign mem_reset_n = (st != S_RST);
  assign mem_cke     = (st != S_RST) && (st != S_CKEW);
  assign mem_cs_n    = !mem_cke;
  assign {mem_ras_n, mem_cas_n, mem_we_n} = cmd;
  assign init_done   = (st == S_DONE);

endmodule

module ddr3_powerup_seq_chk #(
  parameter int BA_W   = 3,
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_reset_n,
  input logic              mem_cke,
  input logic              mem_cs_n,
  input logic              mem_ras_n,
  input logic              mem_cas_n,
  input logic              mem_we_n,
  input logic [BA_W-1:0]   mem_ba,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              init_done
);
  logic [2:0] c;
  logic is_nop, is_mrs, is_ref, is_pre, is_zq;
  assign c      = {mem_ras_n, mem_cas_n, mem_we_n};
  assign is_nop = !mem_cs_n && (c == 3'b111);
  assign is_mrs = !mem_cs_n && (c == 3'b000);
  assign is_ref = !mem_cs_n && (c == 3'b001);
  assign is_pre = !mem_cs_n && (c == 3'b010);
  assign is_zq  = !mem_cs_n && (c == 3'b110);

  always @(negedge clk)
    if (!rst_n)
      a_r1_held_in_reset: assert (!mem_reset_n && !mem_cke && !init_done && mem_cs_n);

  a_r2_cke_needs_reset_n: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke |-> mem_reset_n);
  a_r2_cke_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke |=> mem_cke);
  a_r3_deselect_before_cke: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cke |-> mem_cs_n);
  a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> (is_nop || is_mrs || is_ref || is_pre || is_zq));
  a_r4_mrs_bank_range: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (mem_ba <= BA_W'(2)));
  a_r6_zq_long_form: assert property (@(posedge clk) disable iff (!rst_n)
    is_zq |-> mem_addr[10]);
  a_r7_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> mem_addr[10]);
  a_r8_nop_after_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |=> is_nop);
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (is_nop && mem_cke));
endmodule

bind ddr3_powerup_seq ddr3_powerup_seq_chk #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_reset_n(mem_reset_n), .mem_cke(mem_cke),
  .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
  .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr), .init_done(init_done)
);

// File: tb/ddr3_powerup_seq_bench.sv
module ddr3_powerup_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BA_W = 3, ADDR_W = 14;
  localparam int T_RESET = 20, T_CKE = 30, T_XPR = 15, T_MRD = 3, T_MOD = 11;
  localparam int T_ZQINIT = 40, T_RP = 3, T_SETTLE = 25;
  localparam int MR2 = 'h040, MR1 = 'h044, MR0 = 'h210;
  localparam int WD_CYCLES = 20000;

  localparam int K_RSTN = 1, K_CKE = 2, K_DONE = 3, K_CMD = 4, K_CKE_FALL = 5,
                 K_RSTN_FALL = 6, K_DONE_FALL = 7;

  typedef struct {
    int         kind;
    logic [2:0] cmd;
    int         ba;
    int         addr;
    int         cyc;
    string      req;
  } ev_t;

  logic clk = 0, rst_n = 0;
  logic mem_reset_n, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, init_done;
  logic [BA_W-1:0]   mem_ba;
  logic [ADDR_W-1:0] mem_addr;

  int checks = 0, fails = 0;
  ev_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr3_powerup_seq #(
    .BA_W(BA_W), .ADDR_W(ADDR_W), .T_RESET(T_RESET), .T_CKE(T_CKE), .T_XPR(T_XPR),
    .T_MRD(T_MRD), .T_MOD(T_MOD), .T_ZQINIT(T_ZQINIT), .T_RP(T_RP), .T_SETTLE(T_SETTLE),
    .MR2_VAL(16'(MR2)), .MR1_VAL(16'(MR1)), .MR0_VAL(16'(MR0))
  ) u_ddr3_powerup_seq (
    .clk(clk), .rst_n(rst_n), .mem_reset_n(mem_reset_n), .mem_cke(mem_cke),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_ba(mem_ba), .mem_addr(mem_addr), .init_done(init_done)
  );

  task automatic push_ev(input int kind, input logic [2:0] cmd, input int ba,
                         input int addr, input int cyc, input string req);
    ev_t e;
    e.kind = kind; e.cmd = cmd; e.ba = ba; e.addr = addr; e.cyc = cyc; e.req = req;
    q.push_back(e);
  endtask

  // Expected event timeline measured in clocks from reset release
  task automatic push_seq(input int n);
    int a, b, m2, m1, m0, zq, pr, rf, dn;
    a  = T_RESET + 1;
    b  = a + T_CKE + 1;
    m2 = b + T_XPR + 1;
    m1 = m2 + T_MRD + 1;
    m0 = m1 + T_MRD + 1;
    zq = m0 + T_MOD + 1;
    pr = zq + T_ZQINIT + 1;
    rf = pr + T_RP + 1;
    dn = rf + T_SETTLE + 2;
    if (n > 0) push_ev(K_RSTN, 3'b111, 0, 0, a, "R1");
    if (n > 1) push_ev(K_CKE, 3'b111, 0, 0, b, "R2");
    if (n > 2) push_ev(K_CMD, 3'b000, 2, MR2, m2, "R4");
    if (n > 3) push_ev(K_CMD, 3'b000, 1, MR1, m1, "R5");
    if (n > 4) push_ev(K_CMD, 3'b000, 0, MR0, m0, "R5");
    if (n > 5) push_ev(K_CMD, 3'b110, 0, 'h400, zq, "R6");
    if (n > 6) push_ev(K_CMD, 3'b010, 0, 'h400, pr, "R7");
    if (n > 7) push_ev(K_CMD, 3'b001, 0, 0, rf, "R7");
    if (n > 8) push_ev(K_DONE, 3'b111, 0, 0, dn, "R8");
  endtask

  task automatic got(input int kind, input int cyc);
    ev_t e;
    checks++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL %s unexpected event kind=%0d cmd=%b ba=%0d addr=%h at cycle %0d, expected none",
               init_done ? "R9" : "R3", kind, {mem_ras_n, mem_cas_n, mem_we_n},
               mem_ba, mem_addr, cyc);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.cyc != cyc ||
          (kind == K_CMD && (e.cmd != {mem_ras_n, mem_cas_n, mem_we_n} ||
                             e.ba != int'(mem_ba) || e.addr != int'(mem_addr)))) begin
        fails++;
        $display("FAIL %s (R3 coding) actual kind=%0d cmd=%b ba=%0d addr=%h cyc=%0d expected kind=%0d cmd=%b ba=%0d addr=%h cyc=%0d",
                 e.req, kind, {mem_ras_n, mem_cas_n, mem_we_n}, mem_ba, mem_addr, cyc,
                 e.kind, e.cmd, e.ba, e.addr, e.cyc);
      end
    end
  endtask

  int   cyc = 0;
  logic p_rn = 0, p_cke = 0, p_dn = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; p_rn = 0; p_cke = 0; p_dn = 0;
    end else begin
      if (mem_reset_n != p_rn) got(mem_reset_n ? K_RSTN : K_RSTN_FALL, cyc);
      if (mem_cke != p_cke) got(mem_cke ? K_CKE : K_CKE_FALL, cyc);
      if (!mem_cs_n && {mem_ras_n, mem_cas_n, mem_we_n} != 3'b111) got(K_CMD, cyc);
      if (init_done != p_dn) got(init_done ? K_DONE : K_DONE_FALL, cyc);
      p_rn = mem_reset_n; p_cke = mem_cke; p_dn = init_done;
      cyc++;
    end
  end

  task automatic check_reset_state(input string req);
    @(negedge clk);
    checks++;
    if (mem_reset_n || mem_cke || init_done || !mem_cs_n) begin
      fails++;
      $display("FAIL %s reset state actual rn=%b cke=%b done=%b cs_n=%b expected rn=0 cke=0 done=0 cs_n=1",
               req, mem_reset_n, mem_cke, init_done, mem_cs_n);
    end
  endtask

  task automatic release_reset();
    @(posedge clk); #1 rst_n = 1;
  endtask

  task automatic apply_reset();
    @(posedge clk); #1 rst_n = 0;
  endtask

  task automatic drain_then_idle(input int idle);
    while (q.size() != 0) @(posedge clk);
    repeat (idle) @(posedge clk);
  endtask

  task automatic check_done(input logic exp, input string req);
    @(negedge clk);
    checks++;
    if (init_done !== exp) begin
      fails++;
      $display("FAIL %s init_done actual %b expected %b", req, init_done, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired, actual done=%b expected 1", init_done);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    check_reset_state("R1");

    // full script; afterwards the pins must stay quiet (R9)
    push_seq(9);
    release_reset();
    drain_then_idle(60);
    check_done(1'b1, "R9");

    // R10: restart during clock-enable wait
    apply_reset();
    check_reset_state("R10");
    push_seq(1);
    release_reset();
    drain_then_idle(5);
    apply_reset();
    check_reset_state("R10");

    // R10: restart right after the last mode write
    push_seq(5);
    release_reset();
    drain_then_idle(2);
    apply_reset();
    check_reset_state("R10");
    check_done(1'b0, "R10");

    // full replay with full gaps after a partial run
    push_seq(9);
    release_reset();
    drain_then_idle(40);
    check_done(1'b1, "R10");

    finish_run();
  end
endmodule